// File: doc/BRIEF.md
# Receive FIFO Status Channel Sequencer

This block produces the two-bit status lines that a packet receiver returns to its transmitter to report how much room each channel's FIFO has. A write port on the status clock loads two-bit channel states into an internal table, sixteen channels per write. The block then streams a fixed cycle on the status lines. Each cycle starts with a framing symbol. The calendar of channel states follows, repeated a configurable number of times. A two-bit diagonal parity code over everything sent since the framing symbol closes the cycle.

Three controls sit beside the stream. A test input makes the next parity code go out inverted, once. An almost-full input, in the out-of-frame mode, forces the lines to framing until it clears. The calendar length and repeat count are captured only while the block is disabled, so a running calendar cannot change shape.

Top module: `sink_status_gen`

## Requirements
- R1: After reset `stat_o` is 2'b11 and every channel in the table holds 2'b00 (starving).
- R2: At any rising edge with `enable_i` low, the sequencer returns to framing, so `stat_o` is 2'b11 from the next cycle on. After `enable_i` rises, one framing symbol is sent and then calendar entry 0 of a fresh cycle.
- R3: The output cycle is a framing symbol 2'b11, then `cal_rep_i+1` passes of `cal_len_i+1` entries, then one parity code, then framing again. Entry i of every pass carries the table state of channel i.
- R4: `cal_len_i` (entry count minus one) and `cal_rep_i` (pass count minus one) are captured at every rising edge where `enable_i` is low. Changes to them while `enable_i` is high have no effect until the block is disabled again.
- R5: A write occurs at a rising edge where `stat_wr_ni` is 0. `stat_addr_i` selects bank b, covering channels 16*b to 16*b+15. For each k with `stat_mask_i[k]`=1, channel 16*b+k takes `stat_word_i[2k+1:2k]`. Channels with mask 0, and banks beyond the channel count, are left unchanged.
- R6: A write field equal to 2'b11 leaves its channel unchanged. Channel states are 00 starving, 01 hungry and 10 satisfied.
- R7: A calendar entry never shows 2'b11 on `stat_o`.
- R8: The parity code is computed with an accumulator p that is cleared at framing. For each calendar word w, in order, p becomes {p[0],p[1]} ^ w. The code sent is ~{p[0],p[1]}.
- R9: A 1 on `dip_err_req_i` at a rising edge makes the next parity code sent equal to the bitwise inverse of the correct code. Several requests before that code still corrupt only that code, and later codes are correct.
- R10: With `af_mode_i`=2'b00, `almost_full_i` high at a rising edge returns the sequencer to framing. The partial cycle and its parity are dropped, and after release one framing symbol is sent before entry 0.
- R11: With `af_mode_i` other than 2'b00, `almost_full_i` does not change the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Status clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Sequencer enable; low sends framing and opens the configuration registers |
| cal_len_i | input | IDX_W | Calendar entries per pass, minus one |
| cal_rep_i | input | REP_W | Calendar passes per cycle, minus one |
| af_mode_i | input | 2 | Almost-full behaviour select; 2'b00 goes out of frame |
| almost_full_i | input | 1 | Receiver almost-full indication |
| dip_err_req_i | input | 1 | Request to invert the next parity code |
| stat_word_i | input | 32 | Sixteen two-bit channel states |
| stat_addr_i | input | 4 | Bank select for the write |
| stat_mask_i | input | 16 | Per-channel write enable |
| stat_wr_ni | input | 1 | Write strobe, active low |
| stat_o | output | 2 | Status lines |

## Verification
The bench places the error request both early in a cycle and twice before one parity code. A design that keeps the request pending would corrupt a second code, and one that ignores the early request would corrupt none. It drops enable, and raises almost-full in the out-of-frame mode, in the middle of a calendar pass. A design that resumes where it stopped, or keeps the old parity, then sends entries or a code that differ from a fresh cycle. It also rewrites the calendar length during a run, and sends table writes with all-ones fields, partial masks and an address past the last bank. These show up as calendars of the wrong length or as table entries that should not have changed.

// File: rtl/sink_stat_pkg.sv
package sink_stat_pkg;
  localparam logic [1:0] FRAME_CODE = 2'b11;
  localparam logic [1:0] AF_MODE_OOF = 2'b00;
  localparam int BANK_CH = 16;

  typedef enum logic [1:0] {
    ST_FRAME = 2'd0,
    ST_CAL   = 2'd1,
    ST_DIP   = 2'd2
  } seq_st_e;

  function automatic logic [1:0] rot2(input logic [1:0] v);
    return {v[0], v[1]};
  endfunction
endpackage

// File: rtl/sink_stat_table.sv
module sink_stat_table
  import sink_stat_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ni,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      word_i,
  input  logic [15:0]      mask_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [1:0]       rd_stat_o
);
  logic [1:0] tbl_q [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int B = c / BANK_CH;
    localparam int K = c % BANK_CH;
    logic hit;
    assign hit = !wr_ni && (addr_i == 4'(B)) && mask_i[K] && (word_i[2*K +: 2] != FRAME_CODE);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tbl_q[c] <= 2'b00;
      else if (hit) tbl_q[c] <= word_i[2*K +: 2];
    end

    a_r5_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ni || addr_i != 4'(B) || !mask_i[K]) |=> $stable(tbl_q[c]));
    a_r6_frame_field_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_i[2*K +: 2] == FRAME_CODE) |=> $stable(tbl_q[c]));
  end

  assign rd_stat_o = tbl_q[rd_idx_i];
endmodule

// File: rtl/sink_stat_cfg.sv
module sink_stat_cfg #(
  parameter int IDX_W = 5,
  parameter int REP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [IDX_W-1:0] len_i,
  input  logic [REP_W-1:0] rep_i,
  output logic [IDX_W-1:0] len_o,
  output logic [REP_W-1:0] rep_o
);
  logic [IDX_W-1:0] len_q;
  logic [REP_W-1:0] rep_q;

  // shadow registers open only while the sequencer is stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '1;
      rep_q <= '0;
    end else if (!enable_i) begin
      len_q <= len_i;
      rep_q <= rep_i;
    end
  end

  assign len_o = len_q;
  assign rep_o = rep_q;

  a_r4_len_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(enable_i) |-> $stable(len_q));
  a_r4_rep_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(enable_i) |-> $stable(rep_q));
endmodule

// File: rtl/sink_stat_seq.sv
module sink_stat_seq
  import sink_stat_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int REP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [1:0]       af_mode_i,
  input  logic             almost_full_i,
  input  logic             err_req_i,
  input  logic [IDX_W-1:0] len_m1_i,
  input  logic [REP_W-1:0] rep_m1_i,
  input  logic [1:0]       rd_stat_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [1:0]       stat_o
);
  seq_st_e          st_q;
  logic [IDX_W-1:0] idx_q;
  logic [REP_W-1:0] rep_q;
  logic [1:0]       par_q;
  logic             err_pend_q;
  logic             hold;

  assign hold = !enable_i || (af_mode_i == AF_MODE_OOF && almost_full_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_pend_q <= 1'b0;
    end else if (st_q == ST_DIP) begin
      err_pend_q <= err_req_i; // current code consumes the pending request
    end else begin
      err_pend_q <= err_pend_q | err_req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FRAME;
      idx_q <= '0;
      rep_q <= '0;
      par_q <= '0;
    end else if (hold) begin
      st_q  <= ST_FRAME;
      idx_q <= '0;
      rep_q <= '0;
      par_q <= '0;
    end else begin
      unique case (st_q)
        ST_FRAME: begin
          st_q  <= ST_CAL;
          idx_q <= '0;
          rep_q <= '0;
          par_q <= '0;
        end
        ST_CAL: begin
          par_q <= rot2(par_q) ^ rd_stat_i;
          if (idx_q == len_m1_i) begin
            idx_q <= '0;
            if (rep_q == rep_m1_i) st_q <= ST_DIP;
            else rep_q <= rep_q + 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_FRAME;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_CAL:  stat_o = rd_stat_i;
      ST_DIP:  stat_o = ~rot2(par_q) ^ {2{err_pend_q}};
      default: stat_o = FRAME_CODE;
    endcase
  end

  assign rd_idx_o = idx_q;

  a_r2_frame_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> stat_o == FRAME_CODE);
  a_r10_out_of_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_mode_i == AF_MODE_OOF && almost_full_i) |=> stat_o == FRAME_CODE);
  a_r7_no_frame_in_cal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CAL) |-> stat_o != FRAME_CODE);
  a_r3_frame_after_dip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DIP) |=> stat_o == FRAME_CODE);
  a_r9_single_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DIP && !err_req_i) |=> !err_pend_q);
endmodule

// File: rtl/sink_status_gen.sv
module sink_status_gen
  import sink_stat_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int REP_W  = 4,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [IDX_W-1:0] cal_len_i,
  input  logic [REP_W-1:0] cal_rep_i,
  input  logic [1:0]       af_mode_i,
  input  logic             almost_full_i,
  input  logic             dip_err_req_i,
  input  logic [31:0]      stat_word_i,
  input  logic [3:0]       stat_addr_i,
  input  logic [15:0]      stat_mask_i,
  input  logic             stat_wr_ni,
  output logic [1:0]       stat_o
);
  logic [IDX_W-1:0] len_m1;
  logic [REP_W-1:0] rep_m1;
  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       rd_stat;

  sink_stat_cfg #(.IDX_W(IDX_W), .REP_W(REP_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .len_i    (cal_len_i),
    .rep_i    (cal_rep_i),
    .len_o    (len_m1),
    .rep_o    (rep_m1)
  );

  sink_stat_table #(.NUM_CH(NUM_CH)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ni     (stat_wr_ni),
    .addr_i    (stat_addr_i),
    .word_i    (stat_word_i),
    .mask_i    (stat_mask_i),
    .rd_idx_i  (rd_idx),
    .rd_stat_o (rd_stat)
  );

  sink_stat_seq #(.IDX_W(IDX_W), .REP_W(REP_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .af_mode_i     (af_mode_i),
    .almost_full_i (almost_full_i),
    .err_req_i     (dip_err_req_i),
    .len_m1_i      (len_m1),
    .rep_m1_i      (rep_m1),
    .rd_stat_i     (rd_stat),
    .rd_idx_o      (rd_idx),
    .stat_o        (stat_o)
  );
endmodule

// File: tb/sink_status_gen_test.sv
module sink_status_gen_test;
  localparam int CLK_P = 10;
  localparam int N_CH  = 32;
  localparam int IW    = $clog2(N_CH);
  localparam int RW    = 4;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          enable;
  logic [IW-1:0] cal_len;
  logic [RW-1:0] cal_rep;
  logic [1:0]    af_mode;
  logic          af;
  logic          err_req;
  logic [31:0]   s_word;
  logic [3:0]    s_addr;
  logic [15:0]   s_mask;
  logic          s_wr_n;
  logic [1:0]    stat_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [1:0] exp_tbl [N_CH];
  logic [1:0] exp_q [$];
  string      tag_q [$];
  logic [1:0] gen_q [$];
  string      gtag_q [$];
  logic [1:0] mon_e;
  string      mon_t;

  always #(CLK_P/2) clk = ~clk;

  sink_status_gen #(.NUM_CH(N_CH), .REP_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable), .cal_len_i(cal_len),
    .cal_rep_i(cal_rep), .af_mode_i(af_mode), .almost_full_i(af),
    .dip_err_req_i(err_req), .stat_word_i(s_word), .stat_addr_i(s_addr),
    .stat_mask_i(s_mask), .stat_wr_ni(s_wr_n), .stat_o(stat_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [1:0] act, input logic [1:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: stat_o=%b expected %b at %0t", tag, act, e, $time);
    end
  endtask

  // monitor: pops one expected symbol per cycle
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      chk(stat_o === mon_e, mon_t, stat_o, mon_e);
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_now(input logic [1:0] e, input string tag);
    @(negedge clk);
    chk(stat_o === e, tag, stat_o, e);
  endtask

  // R8 reference parity
  function automatic logic [1:0] calc_dip(input int len_m1, input int rep_m1);
    logic [1:0] p = 2'b00;
    for (int r = 0; r <= rep_m1; r++)
      for (int i = 0; i <= len_m1; i++)
        p = {p[0], p[1]} ^ exp_tbl[i];
    return ~{p[0], p[1]};
  endfunction

  // one framing + calendar + parity cycle into gen_q
  task automatic gen_frame(input int len_m1, input int rep_m1, input logic inv,
                           input string etag, input string dtag);
    gen_q.push_back(2'b11); gtag_q.push_back("R3");
    for (int r = 0; r <= rep_m1; r++)
      for (int i = 0; i <= len_m1; i++) begin
        gen_q.push_back(exp_tbl[i]); gtag_q.push_back(etag);
      end
    gen_q.push_back(calc_dip(len_m1, rep_m1) ^ {2{inv}}); gtag_q.push_back(dtag);
  endtask

  task automatic push_gen(input int n);
    int lim = (n < 0) ? gen_q.size() : n;
    for (int i = 0; i < lim; i++) begin
      exp_q.push_back(gen_q[i]); tag_q.push_back(gtag_q[i]);
    end
    gen_q.delete(); gtag_q.delete();
  endtask

  task automatic push_one(input logic [1:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic wr_stat(input logic [3:0] a, input logic [31:0] w, input logic [15:0] m);
    cyc();
    s_addr = a; s_word = w; s_mask = m; s_wr_n = 1'b0;
    cyc();
    s_wr_n = 1'b1;
    if (int'(a) < N_CH/16)
      for (int k = 0; k < 16; k++)
        if (m[k] && w[2*k +: 2] != 2'b11) exp_tbl[int'(a)*16 + k] = w[2*k +: 2];
  endtask

  task automatic set_cfg(input int l, input int r);
    cal_len = IW'(l); cal_rep = RW'(r);
    cyc();
  endtask

  task automatic drain_stop();
    wait (exp_q.size() == 0);
    cyc();
    enable = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst_ni = 1'b0; enable = 1'b0; cal_len = '0; cal_rep = '0; af_mode = 2'b00;
    af = 1'b0; err_req = 1'b0; s_word = '0; s_addr = '0; s_mask = '0; s_wr_n = 1'b1;
    for (int i = 0; i < N_CH; i++) exp_tbl[i] = 2'b00;
    repeat (3) cyc();
    rst_ni = 1'b1;
    expect_now(2'b11, "R1");
    expect_now(2'b11, "R1");

    // R1 table starts starving, R3 short calendar
    set_cfg(3, 0);
    gen_frame(3, 0, 1'b0, "R1", "R8"); push_gen(-1);
    enable = 1'b1;
    drain_stop();
    expect_now(2'b11, "R2");
    expect_now(2'b11, "R2");

    // R5/R6 table writes
    w = '0; for (int k = 0; k < 16; k++) w[2*k +: 2] = 2'(k % 3);
    wr_stat(4'd0, w, 16'hFFFF);
    w = '0; for (int k = 0; k < 16; k++) w[2*k +: 2] = 2'((k + 1) % 3);
    wr_stat(4'd1, w, 16'hFFFF);
    wr_stat(4'd0, {16{2'b10}}, 16'h00F0);
    wr_stat(4'd1, {16{2'b11}}, 16'hFFFF);
    wr_stat(4'd1, {8{2'b01, 2'b11}}, 16'hFFFF);
    wr_stat(4'd3, 32'h0, 16'hFFFF);
    set_cfg(N_CH - 1, 1);
    gen_frame(N_CH - 1, 1, 1'b0, "R5", "R8");
    gen_frame(N_CH - 1, 1, 1'b0, "R6", "R8");
    push_gen(-1);
    enable = 1'b1;
    drain_stop();

    // R9 forced parity error, two requests before one code
    set_cfg(7, 0);
    gen_frame(7, 0, 1'b1, "R3", "R9");
    gen_frame(7, 0, 1'b0, "R3", "R9");
    gen_frame(7, 0, 1'b0, "R7", "R9");
    push_gen(-1);
    enable = 1'b1; err_req = 1'b1;
    cyc(); err_req = 1'b0;
    cyc(); err_req = 1'b1;
    cyc(); err_req = 1'b0;
    drain_stop();

    // R4 config frozen while enabled
    set_cfg(4, 1);
    gen_frame(4, 1, 1'b0, "R4", "R4");
    gen_frame(4, 1, 1'b0, "R4", "R4");
    push_gen(-1);
    enable = 1'b1;
    cyc(); cal_len = IW'(9); cal_rep = RW'(0);
    drain_stop();
    cyc();
    gen_frame(9, 0, 1'b0, "R4", "R4"); push_gen(-1);
    enable = 1'b1;
    drain_stop();

    // R2 disable mid calendar, fresh restart
    set_cfg(7, 0);
    gen_frame(7, 0, 1'b0, "R2", "R2"); push_gen(4);
    push_one(2'b11, "R2");
    gen_frame(7, 0, 1'b0, "R2", "R2"); push_gen(-1);
    enable = 1'b1;
    repeat (3) cyc();
    enable = 1'b0;
    repeat (2) cyc();
    enable = 1'b1;
    drain_stop();

    // R10 almost-full from start
    af_mode = 2'b00;
    cyc();
    for (int i = 0; i < 3; i++) push_one(2'b11, "R10");
    gen_frame(7, 0, 1'b0, "R10", "R10"); push_gen(-1);
    enable = 1'b1; af = 1'b1;
    repeat (3) cyc();
    af = 1'b0;
    drain_stop();

    // R10 almost-full mid calendar
    cyc();
    gen_frame(7, 0, 1'b0, "R10", "R10"); push_gen(5);
    for (int i = 0; i < 2; i++) push_one(2'b11, "R10");
    gen_frame(7, 0, 1'b0, "R10", "R10"); push_gen(-1);
    enable = 1'b1;
    repeat (4) cyc();
    af = 1'b1;
    repeat (3) cyc();
    af = 1'b0;
    drain_stop();

    // R11 other mode ignores almost-full
    af_mode = 2'b01;
    cyc();
    gen_frame(7, 0, 1'b0, "R11", "R11"); push_gen(-1);
    enable = 1'b1;
    repeat (4) cyc();
    af = 1'b1;
    repeat (3) cyc();
    af = 1'b0;
    drain_stop();
    expect_now(2'b11, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule